// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Truncating Converter

This block turns a 32-bit IEEE-754 single-precision number into a two's-complement integer, always discarding the fraction so the result moves toward zero. No rounding-mode setting anywhere in the chip can change this. A width-select input picks the result width. In wide mode the result is a full 64-bit signed integer. In narrow mode it is a 32-bit signed integer placed in the low half of the 64-bit output, with the upper half cleared.

Next to the integer the block reports two flags. One flags a value the chosen width cannot represent. Infinities and NaNs also count as such values, and they return a fixed indefinite code that has only the sign bit set. The other flag marks a conversion that threw away nonzero fraction bits.

The source bus may be wider than 32 bits, as when the value sits in the low lane of a vector register. Only the low 32 bits are converted. Inputs are accepted under a valid strobe, and the results come out of registers one cycle later.

Top module: `fp32_trunc_conv`

## Requirements
- R1: Only `src_word[31:0]` is converted; bits above 31 never change `result`, `invalid_flag` or `inexact_flag`.
- R2: A value with a fractional part converts to the integer nearest zero (2.75 gives 2, -2.75 gives -2).
- R3: With `wide_sel`=1 an in-range value appears as a 64-bit two's-complement integer on `result[63:0]`.
- R4: With `wide_sel`=0 an in-range value appears as a 32-bit two's-complement integer on `result[31:0]`, and `result[63:32]` is zero.
- R5: With `wide_sel`=0, a truncated value below -2^31 or above 2^31-1 gives `result` = 0x0000_0000_8000_0000 and `invalid_flag`=1.
- R6: With `wide_sel`=1, a truncated value below -2^63 or above 2^63-1 gives `result` = 0x8000_0000_0000_0000 and `invalid_flag`=1.
- R7: `inexact_flag` is 1 exactly when nonzero fraction bits were dropped and the result is not invalid; the two flags are never both 1.
- R8: A NaN or infinity (exponent field bits [30:23] all ones) gives the indefinite code of the selected width, `invalid_flag`=1 and `inexact_flag`=0.
- R9: -2^31 in narrow mode (0xCF000000) and -2^63 in wide mode (0xDF000000) convert exactly, with no invalid flag.
- R10: +0 and -0 give 0 with both flags clear; a subnormal gives 0 with `inexact_flag`=1.
- R11: Results and `out_valid` appear one clock after `in_valid`; `out_valid` is 0 one clock after a cycle without `in_valid`; synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source operand present this cycle |
| src_word | input | SRC_W (64) | Source operand; bits [31:0] hold the single-precision value |
| wide_sel | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| out_valid | output | 1 | Registered result is valid |
| result | output | WIDE_W (64) | Converted integer or indefinite code |
| invalid_flag | output | 1 | Value not representable in the selected width |
| inexact_flag | output | 1 | Fraction bits were discarded |

## Verification
Every output is registered once, so a conversion presented before rising edge N can be observed right after edge N, and nothing is due earlier. The bench drives each operand on a falling edge and waits for the next rising edge. It samples one nanosecond after that edge, so each result is compared in the cycle it first becomes valid. The model sweeps every exponent code, both signs, both widths and several mantissa patterns. It also checks that `out_valid` drops one cycle after the strobe is withdrawn.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int FP_W     = 32;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;
  localparam int FP_SIG_W = FP_MAN_W + 1;
  localparam int FP_BIAS  = (1 << (FP_EXP_W - 1)) - 1;

  typedef struct packed {
    logic                sgn;
    logic                special;   // exponent all ones: NaN or infinity
    logic                subnorm;   // exponent all zeros: zero or subnormal
    logic [FP_EXP_W-1:0] expo;
    logic [FP_SIG_W-1:0] sig;       // significand with hidden bit restored
  } fp_fields_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [FP_W-1:0] bits_in,
  output fp_fields_t      fields
);
  logic [FP_EXP_W-1:0] expo;
  logic [FP_MAN_W-1:0] man;

  assign expo = bits_in[FP_W-2 -: FP_EXP_W];
  assign man  = bits_in[FP_MAN_W-1:0];

  always_comb begin
    fields.sgn     = bits_in[FP_W-1];
    fields.special = &expo;
    fields.subnorm = ~|expo;
    fields.expo    = expo;
    fields.sig     = {~fields.subnorm, man};
  end
endmodule

// File: rtl/fcvt_magnitude.sv
module fcvt_magnitude
  import fcvt_pkg::*;
#(
  parameter int WIDE_W = 64
) (
  input  logic                special,
  input  logic                subnorm,
  input  logic [FP_EXP_W-1:0] expo,
  input  logic [FP_SIG_W-1:0] sig,
  output logic [WIDE_W-1:0]   mag,
  output logic                lost,
  output logic                huge
);
  // exponent code at which the significand lsb has weight one
  localparam int POINT    = FP_BIAS + FP_MAN_W;
  // exponent code at which the magnitude reaches 2^WIDE_W
  localparam int HUGE_EXP = FP_BIAS + WIDE_W;

  logic [WIDE_W-1:0] sig_ext;
  int                e_int;
  int                rsh;

  assign sig_ext = WIDE_W'(sig);
  assign e_int   = int'(expo);

  always_comb begin
    mag  = '0;
    lost = 1'b0;
    huge = 1'b0;
    rsh  = 0;
    if (special) begin
      huge = 1'b1;
    end else if (subnorm) begin
      lost = |sig;
    end else if (e_int >= HUGE_EXP) begin
      huge = 1'b1;
    end else if (e_int >= POINT) begin
      mag = sig_ext << (e_int - POINT);
    end else begin
      rsh  = POINT - e_int;
      mag  = sig_ext >> rsh;
      lost = ((mag << rsh) != sig_ext);
    end
  end
endmodule

// File: rtl/fcvt_pack.sv
module fcvt_pack #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              sgn,
  input  logic [WIDE_W-1:0] mag,
  input  logic              lost,
  input  logic              huge,
  input  logic              wide,
  output logic [WIDE_W-1:0] value,
  output logic              invalid,
  output logic              inexact
);
  localparam logic [WIDE_W-1:0] WIDE_LIM   = WIDE_W'(1) << (WIDE_W - 1);
  localparam logic [WIDE_W-1:0] NARROW_LIM = WIDE_W'(1) << (NARROW_W - 1);

  logic              fits_wide;
  logic              fits_narrow;
  logic              ok;
  logic [WIDE_W-1:0] signed_val;

  assign fits_wide   = !huge && ((mag < WIDE_LIM)   || (sgn && mag == WIDE_LIM));
  assign fits_narrow = !huge && ((mag < NARROW_LIM) || (sgn && mag == NARROW_LIM));
  assign signed_val  = sgn ? (~mag + WIDE_W'(1)) : mag;
  assign ok          = wide ? fits_wide : fits_narrow;

  always_comb begin
    if (wide) begin
      value = ok ? signed_val : WIDE_LIM;
    end else begin
      value = ok ? {{(WIDE_W-NARROW_W){1'b0}}, signed_val[NARROW_W-1:0]} : NARROW_LIM;
    end
    invalid = !ok;
    inexact = ok && lost;
  end
endmodule

// File: rtl/fp32_trunc_conv.sv
module fp32_trunc_conv
  import fcvt_pkg::*;
#(
  parameter int SRC_W    = 64,
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SRC_W-1:0]  src_word,
  input  logic              wide_sel,
  output logic              out_valid,
  output logic [WIDE_W-1:0] result,
  output logic              invalid_flag,
  output logic              inexact_flag
);
  fp_fields_t        fields;
  logic [WIDE_W-1:0] mag;
  logic              lost;
  logic              huge;
  logic [WIDE_W-1:0] value;
  logic              invalid;
  logic              inexact;

  fcvt_unpack u_unpack (
    .bits_in (src_word[FP_W-1:0]),
    .fields  (fields)
  );

  fcvt_magnitude #(.WIDE_W(WIDE_W)) u_mag (
    .special (fields.special),
    .subnorm (fields.subnorm),
    .expo    (fields.expo),
    .sig     (fields.sig),
    .mag     (mag),
    .lost    (lost),
    .huge    (huge)
  );

  fcvt_pack #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_pack (
    .sgn     (fields.sgn),
    .mag     (mag),
    .lost    (lost),
    .huge    (huge),
    .wide    (wide_sel),
    .value   (value),
    .invalid (invalid),
    .inexact (inexact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      invalid_flag <= 1'b0;
      inexact_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= value;
        invalid_flag <= invalid;
        inexact_flag <= inexact;
      end
    end
  end
endmodule

// File: rtl/fcvt_checker.sv
module fcvt_checker #(
  parameter int SRC_W    = 64,
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SRC_W-1:0]  src_word,
  input logic              wide_sel,
  input logic              out_valid,
  input logic [WIDE_W-1:0] result,
  input logic              invalid_flag,
  input logic              inexact_flag
);
  localparam logic [WIDE_W-1:0] WIDE_INDEF   = WIDE_W'(1) << (WIDE_W - 1);
  localparam logic [WIDE_W-1:0] NARROW_INDEF = WIDE_W'(1) << (NARROW_W - 1);

  logic [31:0] fp_bits;
  logic        special_in;
  assign fp_bits    = src_word[31:0];
  assign special_in = &fp_bits[30:23];

  // R11: one-cycle valid pipeline
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7: flags mutually exclusive
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(invalid_flag && inexact_flag));

  // R8: NaN and infinity are invalid and never inexact
  a_r8_special_invalid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && special_in && wide_sel) |=> (invalid_flag && !inexact_flag && result == WIDE_INDEF));
  a_r8_special_narrow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && special_in && !wide_sel) |=> (invalid_flag && !inexact_flag && result == NARROW_INDEF));

  // R10: signed zero gives zero with no flags
  a_r10_zero_clean: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fp_bits[30:0] == 31'd0) |=> (result == '0 && !invalid_flag && !inexact_flag));

  // R4: narrow mode clears the upper half
  a_r4_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_sel) |=> (result[WIDE_W-1:NARROW_W] == '0));

  // R5: narrow-mode invalid returns the narrow indefinite code
  a_r5_narrow_indef: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_sel) |=> (!invalid_flag || result == NARROW_INDEF));

  // R6: wide-mode invalid returns the wide indefinite code
  a_r6_wide_indef: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_sel) |=> (!invalid_flag || result == WIDE_INDEF));
endmodule

bind fp32_trunc_conv fcvt_checker #(
  .SRC_W(SRC_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)
) u_fcvt_checker (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .src_word     (src_word),
  .wide_sel     (wide_sel),
  .out_valid    (out_valid),
  .result       (result),
  .invalid_flag (invalid_flag),
  .inexact_flag (inexact_flag)
);

// File: tb/test_fp32_trunc_conv.sv
`timescale 1ns/1ps
module test_fp32_trunc_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src_word = '0;
  logic        wide_sel = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid_flag;
  logic        inexact_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fp32_trunc_conv i_fp32_trunc_conv (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .src_word     (src_word),
    .wide_sel     (wide_sel),
    .out_valid    (out_valid),
    .result       (result),
    .invalid_flag (invalid_flag),
    .inexact_flag (inexact_flag)
  );

  // arithmetic reference: value = sig * 2^(e-150), truncated toward zero
  task automatic model(input logic [31:0] x, input logic w,
                       output logic [63:0] r, output logic inv, output logic inx,
                       output string tag);
    int                   e;
    logic [127:0]         sig;
    logic [127:0]         mag;
    logic signed [127:0]  v;
    logic signed [127:0]  lo;
    logic signed [127:0]  hi;
    logic                 frac;
    e    = int'(x[30:23]);
    frac = 1'b0;
    tag  = w ? "R3" : "R4";
    if (e == 255) begin
      inv = 1'b1; inx = 1'b0; tag = "R8";
      r   = w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
      return;
    end
    if (e == 0) begin
      mag  = '0;
      frac = (x[22:0] != 0);
      tag  = "R10";
    end else begin
      sig = {104'd0, 1'b1, x[22:0]};
      if (e >= 150) begin
        mag = (e - 150 > 60) ? (128'd1 << 100) : sig * (128'd1 << (e - 150));
      end else if (150 - e >= 25) begin
        mag = '0; frac = 1'b1;
      end else begin
        mag  = sig / (128'd1 << (150 - e));
        frac = (sig % (128'd1 << (150 - e))) != 0;
      end
    end
    v  = x[31] ? -$signed(mag) : $signed(mag);
    lo = w ? -(128'sd1 <<< 63) : -(128'sd1 <<< 31);
    hi = w ? (128'sd1 <<< 63) - 1 : (128'sd1 <<< 31) - 1;
    if (v < lo || v > hi) begin
      inv = 1'b1; inx = 1'b0; tag = w ? "R6" : "R5";
      r   = w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    end else begin
      inv = 1'b0; inx = frac;
      r   = w ? v[63:0] : {32'd0, v[31:0]};
      if (v == lo) tag = "R9";
      else if (frac && tag != "R10") tag = "R2/R7";
    end
  endtask

  task automatic apply(input logic [63:0] src, input logic w, input string force_tag);
    logic [63:0] er;
    logic        ei, ex;
    string       tag;
    model(src[31:0], w, er, ei, ex, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    in_valid = 1'b1;
    src_word = src;
    wide_sel = w;
    @(posedge clk);
    #1;
    checks++;
    if (!out_valid || result !== er || invalid_flag !== ei || inexact_flag !== ex) begin
      fails++;
      $display("FAIL %s src=%h wide=%0d: got v=%0d r=%h inv=%0d inx=%0d, expected v=1 r=%h inv=%0d inx=%0d",
               tag, src, w, out_valid, result, invalid_flag, inexact_flag, er, ei, ex);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 || invalid_flag !== 1'b0 || inexact_flag !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: got v=%0d r=%h inv=%0d inx=%0d, expected all zero",
               out_valid, result, invalid_flag, inexact_flag);
    end
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    apply(64'h0000_0000_4030_0000, 1'b0, "R2");   // 2.75 -> 2
    apply(64'h0000_0000_C030_0000, 1'b1, "R2");   // -2.75 -> -2
    apply(64'h0000_0000_CF00_0000, 1'b0, "R9");   // -2^31 narrow
    apply(64'h0000_0000_4F00_0000, 1'b0, "R5");   // +2^31 narrow
    apply(64'h0000_0000_DF00_0000, 1'b1, "R9");   // -2^63 wide
    apply(64'h0000_0000_5F00_0000, 1'b1, "R6");   // +2^63 wide
    apply(64'h0000_0000_7FC0_0000, 1'b1, "R8");   // NaN
    apply(64'h0000_0000_FF80_0000, 1'b0, "R8");   // -infinity
    apply(64'h0000_0000_8000_0000, 1'b1, "R10");  // -0
    apply(64'h0000_0000_0000_0001, 1'b0, "R10");  // smallest subnormal
    apply(64'h0000_0000_4F00_0000, 1'b1, "R3");   // 2^31 fits wide
    apply(64'h0000_0000_C000_0000, 1'b0, "R4");   // -2 narrow

    // upper source bits ignored
    for (int i = 0; i < 64; i++) begin
      logic [31:0] lw;
      lw = $urandom;
      apply({32'd0, lw}, i[0], "R1");
      apply({32'hFFFF_FFFF, lw}, i[0], "R1");
      apply({$urandom, lw}, i[0], "R1");
    end

    // sweep: all exponents, both signs, both widths, several mantissas
    for (int e = 0; e < 256; e++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 5; k++) begin
          logic [22:0] m;
          case (k)
            0: m = 23'd0;
            1: m = 23'd1;
            2: m = 23'h40_0000;
            3: m = 23'h7F_FFFF;
            default: m = 23'(e * 32'h1357) ^ 23'h2_A5A5;
          endcase
          for (int w = 0; w < 2; w++) begin
            apply({$urandom, s[0], e[7:0], m}, w[0], "");
          end
        end
      end
    end

    // strobe withdrawn: out_valid drops one cycle later
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 idle: got out_valid=%0d, expected 0", out_valid);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule